// File: doc/BRIEF.md
# Per-Thread PC-Tagged Functional-Unit Usage Table

This block keeps, for each hardware thread of a simultaneous multithreaded core, a small fully associative table that links a program-counter value to the expected use of each functional-unit class from that address onward. A fetch-selection stage queries it with a thread number and a fetch PC. One cycle later it gets back a hit flag and the stored usage vector. It can then weigh candidate threads by how much they would compete for execution units. Because entries are keyed by PC, a loop body that changes usage needs its hint executed only once, not on every iteration.

Hints arrive through an install port after the hint instruction has executed. Each install names a thread, a PC, one unit class and a 4-bit usage value, so it writes exactly one field of one entry. When a thread's table holds no entry for that PC, a fresh entry is claimed. Empty slots are used first. Once every slot of the thread is occupied, the least recently used entry is overwritten. Both lookup hits and installs count as uses.

Top module: `fu_usage_table`

## Requirements
- R1: After reset every entry of every thread is invalid, so any lookup reports a miss with a usage vector of all zeros.
- R2: A lookup presented in cycle N gives its hit flag and usage vector in cycle N+1. In a cycle after no lookup was presented, the hit flag is 0 and the vector is 0. A miss always returns a vector of 0.
- R3: An install to a PC not present in the thread's table creates a valid entry. In that entry, the field of the addressed unit holds the value and every other field is 0. Unit u occupies usage bits [4u+3:4u].
- R4: An install to a PC already present in the thread's table rewrites only the addressed unit field and keeps the other fields.
- R5: Each thread has its own table. Installs and lookups for one thread neither hit on nor change another thread's entries.
- R6: While a thread has an invalid entry, a new PC takes that entry, and no valid entry is evicted.
- R7: When all entries of a thread are valid, a new PC replaces the least recently used entry of that thread.
- R8: A lookup hit marks the hit entry most recently used.
- R9: A lookup miss changes no recency state.
- R10: A lookup and an install in the same cycle: the lookup returns the contents as they were before that install.
- R11: An install that updates an existing entry marks that entry most recently used. When a lookup hit and an install touch the same thread in one cycle, the installed entry ends up most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Install request strobe |
| instThread | input | 3 | Thread whose table is written |
| instPc | input | 32 | PC tag of the installed hint |
| instUnit | input | 3 | Unit class whose field is written |
| instValue | input | 4 | Usage value for that unit |
| lkValid | input | 1 | Lookup request strobe |
| lkThread | input | 3 | Thread whose table is searched |
| lkPc | input | 32 | Fetch PC to match |
| lkHit | output | 1 | Lookup result hit flag, one cycle after request |
| lkUsage | output | 32 | Eight 4-bit usage fields of the hit entry, 0 on miss |

## Verification
The assertions take for granted that thread numbers stay below the thread count. They also rely on the table only ever being written through the install port, so that a PC tag appears at most once per thread and the recency ages of a thread stay a permutation. The stimulus uses only thread numbers 0 to 2. It writes through the install port only, and it fills, refreshes and evicts entries in a known order, so every expected hit, miss and usage vector follows from the requirements alone.

// File: rtl/usage_tbl_pkg.sv
package usage_tbl_pkg;
  parameter int THREADS = 6;
  parameter int ENTRIES = 4;
  parameter int UNITS   = 8;
  parameter int USE_W   = 4;
  parameter int PC_W    = 32;

  localparam int TID_W  = $clog2(THREADS);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int UNIT_W = $clog2(UNITS);
  localparam int VEC_W  = UNITS * USE_W;

  typedef logic [IDX_W-1:0]              idx_t;
  typedef logic [ENTRIES-1:0][IDX_W-1:0] ageVec_t;

  // Control-to-datapath strobes for one table write
  typedef struct packed {
    logic             wrEn;
    logic             alloc;
    logic [TID_W-1:0] thread;
    idx_t             entry;
  } tblStrobe_t;

  // Make entry k youngest (age 0); entries younger than k age by one
  function automatic ageVec_t touchAge(ageVec_t a, idx_t k);
    ageVec_t r;
    r = a;
    for (int i = 0; i < ENTRIES; i++) begin
      if (a[i] < a[k]) r[i] = a[i] + 1'b1;
    end
    r[k] = '0;
    return r;
  endfunction
endpackage

// File: rtl/usage_tbl_store.sv
module usage_tbl_store
  import usage_tbl_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  tblStrobe_t              strobe,
  input  logic [TID_W-1:0]        instThread,
  input  logic [PC_W-1:0]         instPc,
  input  logic [UNIT_W-1:0]       instUnit,
  input  logic [USE_W-1:0]        instValue,
  input  logic                    lkValid,
  input  logic [TID_W-1:0]        lkThread,
  input  logic [PC_W-1:0]         lkPc,
  output logic                    instMatch,
  output idx_t                    instMatchIdx,
  output logic [ENTRIES-1:0]      instValidVec,
  output logic                    lkMatch,
  output idx_t                    lkMatchIdx,
  output logic                    lkHitQ,
  output logic [VEC_W-1:0]        lkUsageQ
);
  logic [ENTRIES-1:0] validQ [THREADS];
  logic [PC_W-1:0]    tagQ   [THREADS][ENTRIES];
  logic [VEC_W-1:0]   usageQ [THREADS][ENTRIES];

  logic [ENTRIES-1:0] instMatchVec, lkMatchVec;
  logic               instThreadOk, lkThreadOk;
  logic [VEC_W-1:0]   fieldMask, fieldVal, writeVec;

  assign instThreadOk = (int'(instThread) < THREADS);
  assign lkThreadOk   = (int'(lkThread) < THREADS);

  // Tag compare, one comparator per entry for each port
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign instMatchVec[e] = instThreadOk && validQ[instThread][e] &&
                             (tagQ[instThread][e] == instPc);
    assign lkMatchVec[e]   = lkThreadOk && validQ[lkThread][e] &&
                             (tagQ[lkThread][e] == lkPc);
    assign instValidVec[e] = instThreadOk && validQ[instThread][e];
  end

  always_comb begin
    instMatchIdx = '0;
    lkMatchIdx   = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (instMatchVec[e]) instMatchIdx = idx_t'(e);
      if (lkMatchVec[e])   lkMatchIdx   = idx_t'(e);
    end
  end
  assign instMatch = |instMatchVec;
  assign lkMatch   = lkValid && (|lkMatchVec);

  // Single-field merge
  assign fieldMask = VEC_W'({USE_W{1'b1}}) << (instUnit * USE_W);
  assign fieldVal  = VEC_W'(instValue) << (instUnit * USE_W);
  always_comb begin
    if (strobe.alloc) writeVec = fieldVal;
    else              writeVec = (usageQ[strobe.thread][strobe.entry] & ~fieldMask) | fieldVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < THREADS; t++) validQ[t] <= '0;
    end else if (strobe.wrEn) begin
      validQ[strobe.thread][strobe.entry] <= 1'b1;
      usageQ[strobe.thread][strobe.entry] <= writeVec;
      if (strobe.alloc) tagQ[strobe.thread][strobe.entry] <= instPc;
    end
  end

  // Lookup result register: reads pre-write contents
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lkHitQ   <= 1'b0;
      lkUsageQ <= '0;
    end else begin
      lkHitQ   <= lkMatch;
      lkUsageQ <= lkMatch ? usageQ[lkThread][lkMatchIdx] : '0;
    end
  end

  AST_LK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> (!lkHitQ && lkUsageQ == '0)); // R2
  AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(instMatchVec) && $onehot0(lkMatchVec)); // R4
  AST_ALLOC_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.alloc) |=> instValidVec[$past(strobe.entry)] ||
      ($past(strobe.thread) != instThread)); // R3
endmodule

// File: rtl/usage_tbl_lru.sv
module usage_tbl_lru
  import usage_tbl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  input  logic [TID_W-1:0]   instThread,
  input  logic               instMatch,
  input  idx_t               instMatchIdx,
  input  logic [ENTRIES-1:0] instValidVec,
  input  logic               lkMatch,
  input  logic [TID_W-1:0]   lkThread,
  input  idx_t               lkMatchIdx,
  output tblStrobe_t         strobe
);
  ageVec_t            ageQ [THREADS];
  ageVec_t            instAges;
  logic [ENTRIES-1:0] oldestVec;
  idx_t               victim, freeIdx, oldIdx;
  logic               instThreadOk;

  assign instThreadOk = (int'(instThread) < THREADS);
  assign instAges     = instThreadOk ? ageQ[instThread] : '0;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_old
    assign oldestVec[e] = (instAges[e] == idx_t'(ENTRIES - 1));
  end

  // Lowest-index free slot, else the oldest entry
  always_comb begin
    freeIdx = '0;
    oldIdx  = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!instValidVec[e]) freeIdx = idx_t'(e);
      if (oldestVec[e])     oldIdx  = idx_t'(e);
    end
    victim = (&instValidVec) ? oldIdx : freeIdx;
  end

  always_comb begin
    strobe.wrEn   = instValid && instThreadOk;
    strobe.alloc  = !instMatch;
    strobe.thread = instThread;
    strobe.entry  = instMatch ? instMatchIdx : victim;
  end

  // Recency update: lookup hit first, install last so it ends youngest
  for (genvar t = 0; t < THREADS; t++) begin : g_age
    ageVec_t nextAge;
    always_comb begin
      nextAge = ageQ[t];
      if (lkMatch && int'(lkThread) == t) nextAge = touchAge(nextAge, lkMatchIdx);
      if (strobe.wrEn && int'(instThread) == t) nextAge = touchAge(nextAge, strobe.entry);
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int e = 0; e < ENTRIES; e++) ageQ[t][e] <= idx_t'(e);
      end else begin
        ageQ[t] <= nextAge;
      end
    end
  end

  AST_FILL_FREE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.alloc && !(&instValidVec)) |-> !instValidVec[strobe.entry]); // R6
  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.alloc && (&instValidVec)) |-> ($countones(oldestVec) == 1)); // R7
  AST_INST_YOUNGEST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> (ageQ[$past(instThread)][$past(strobe.entry)] == '0)); // R11
endmodule

// File: rtl/fu_usage_table.sv
module fu_usage_table
  import usage_tbl_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    instValid,
  input  logic [TID_W-1:0]        instThread,
  input  logic [PC_W-1:0]         instPc,
  input  logic [UNIT_W-1:0]       instUnit,
  input  logic [USE_W-1:0]        instValue,
  input  logic                    lkValid,
  input  logic [TID_W-1:0]        lkThread,
  input  logic [PC_W-1:0]         lkPc,
  output logic                    lkHit,
  output logic [VEC_W-1:0]        lkUsage
);
  tblStrobe_t         strobe;
  logic               instMatch, lkMatch;
  idx_t               instMatchIdx, lkMatchIdx;
  logic [ENTRIES-1:0] instValidVec;

  usage_tbl_lru ctrl_i (
    .clk(clk), .rstN(rstN),
    .instValid(instValid), .instThread(instThread),
    .instMatch(instMatch), .instMatchIdx(instMatchIdx),
    .instValidVec(instValidVec),
    .lkMatch(lkMatch), .lkThread(lkThread), .lkMatchIdx(lkMatchIdx),
    .strobe(strobe)
  );

  usage_tbl_store store_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .instThread(instThread), .instPc(instPc),
    .instUnit(instUnit), .instValue(instValue),
    .lkValid(lkValid), .lkThread(lkThread), .lkPc(lkPc),
    .instMatch(instMatch), .instMatchIdx(instMatchIdx),
    .instValidVec(instValidVec),
    .lkMatch(lkMatch), .lkMatchIdx(lkMatchIdx),
    .lkHitQ(lkHit), .lkUsageQ(lkUsage)
  );
endmodule

// File: tb/fu_usage_table_tb.sv
module fu_usage_table_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0, lkValid = 1'b0;
  logic [2:0]  instThread = '0, lkThread = '0, instUnit = '0;
  logic [31:0] instPc = '0, lkPc = '0;
  logic [3:0]  instValue = '0;
  logic        lkHit;
  logic [31:0] lkUsage;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  fu_usage_table dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instThread(instThread),
    .instPc(instPc), .instUnit(instUnit), .instValue(instValue),
    .lkValid(lkValid), .lkThread(lkThread), .lkPc(lkPc),
    .lkHit(lkHit), .lkUsage(lkUsage)
  );

  typedef struct packed {
    logic        isInst;
    logic [2:0]  thr;
    logic [31:0] pc;
    logic [2:0]  unit;
    logic [3:0]  val;
    logic        expHit;
    logic [31:0] expUse;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 32'h100, 3'd0, 4'h0, 1'b0, 32'h0,        4'd1},  // R1 empty
    '{1'b1, 3'd0, 32'h100, 3'd2, 4'h5, 1'b0, 32'h0,        4'd3},
    '{1'b0, 3'd0, 32'h100, 3'd0, 4'h0, 1'b1, 32'h00000500, 4'd3},  // R3 new entry
    '{1'b1, 3'd0, 32'h100, 3'd7, 4'hA, 1'b0, 32'h0,        4'd4},
    '{1'b0, 3'd0, 32'h100, 3'd0, 4'h0, 1'b1, 32'hA0000500, 4'd4},  // R4 merge
    '{1'b0, 3'd1, 32'h100, 3'd0, 4'h0, 1'b0, 32'h0,        4'd5},  // R5 other thread
    '{1'b1, 3'd1, 32'h100, 3'd0, 4'h3, 1'b0, 32'h0,        4'd5},
    '{1'b0, 3'd1, 32'h100, 3'd0, 4'h0, 1'b1, 32'h00000003, 4'd5},  // R5
    '{1'b0, 3'd0, 32'h100, 3'd0, 4'h0, 1'b1, 32'hA0000500, 4'd5},  // R5 untouched
    '{1'b1, 3'd0, 32'h200, 3'd1, 4'h1, 1'b0, 32'h0,        4'd6},
    '{1'b1, 3'd0, 32'h300, 3'd1, 4'h2, 1'b0, 32'h0,        4'd6},
    '{1'b1, 3'd0, 32'h400, 3'd1, 4'h3, 1'b0, 32'h0,        4'd6},
    '{1'b0, 3'd0, 32'h400, 3'd0, 4'h0, 1'b1, 32'h00000030, 4'd6},  // R6 all kept
    '{1'b0, 3'd0, 32'h100, 3'd0, 4'h0, 1'b1, 32'hA0000500, 4'd8},  // R8 refresh
    '{1'b0, 3'd0, 32'h999, 3'd0, 4'h0, 1'b0, 32'h0,        4'd9},  // R9 miss
    '{1'b1, 3'd0, 32'h500, 3'd3, 4'h4, 1'b0, 32'h0,        4'd7},
    '{1'b0, 3'd0, 32'h200, 3'd0, 4'h0, 1'b0, 32'h0,        4'd7},  // R7 evicted
    '{1'b0, 3'd0, 32'h100, 3'd0, 4'h0, 1'b1, 32'hA0000500, 4'd8},  // R8 survived
    '{1'b0, 3'd0, 32'h500, 3'd0, 4'h0, 1'b1, 32'h00004000, 4'd3},  // R3
    '{1'b0, 3'd0, 32'h300, 3'd0, 4'h0, 1'b1, 32'h00000020, 4'd9},  // R9 survived
    '{1'b1, 3'd0, 32'h400, 3'd2, 4'h1, 1'b0, 32'h0,        4'd11},
    '{1'b1, 3'd0, 32'h600, 3'd0, 4'h7, 1'b0, 32'h0,        4'd11},
    '{1'b0, 3'd0, 32'h100, 3'd0, 4'h0, 1'b0, 32'h0,        4'd11}, // R11 oldest gone
    '{1'b0, 3'd0, 32'h400, 3'd0, 4'h0, 1'b1, 32'h00000130, 4'd11}, // R11 refreshed
    '{1'b0, 3'd0, 32'h600, 3'd0, 4'h0, 1'b1, 32'h00000007, 4'd3},  // R3
    '{1'b0, 3'd1, 32'h100, 3'd0, 4'h0, 1'b1, 32'h00000003, 4'd5}   // R5
  };

  task automatic check(input string req, input logic hit, input logic [31:0] use_,
                       input logic expHit, input logic [31:0] expUse);
    checks++;
    if (hit !== expHit || use_ !== expUse) begin
      failures++;
      $display("FAIL %s: hit=%0b usage=%08h expected hit=%0b usage=%08h",
               req, hit, use_, expHit, expUse);
    end
  endtask

  task automatic idle();
    instValid = 1'b0;
    lkValid   = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run hung, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset", lkHit, lkUsage, 1'b0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      instValid  = VECS[i].isInst;
      lkValid    = !VECS[i].isInst;
      instThread = VECS[i].thr;   lkThread = VECS[i].thr;
      instPc     = VECS[i].pc;    lkPc     = VECS[i].pc;
      instUnit   = VECS[i].unit;  instValue = VECS[i].val;
      @(negedge clk);
      if (!VECS[i].isInst)
        check($sformatf("R%0d vec%0d", VECS[i].req, i), lkHit, lkUsage,
              VECS[i].expHit, VECS[i].expUse);
    end

    // R2: no lookup presented, result clears
    idle();
    @(negedge clk);
    check("R2 idle", lkHit, lkUsage, 1'b0, 32'h0);

    // R10: same-cycle install and lookup sees old contents
    instValid = 1'b1; instThread = 3'd2; instPc = 32'h700; instUnit = 3'd5; instValue = 4'h9;
    lkValid   = 1'b1; lkThread   = 3'd2; lkPc   = 32'h700;
    @(negedge clk);
    check("R10 same cycle", lkHit, lkUsage, 1'b0, 32'h0);
    instValid = 1'b0;
    @(negedge clk);
    check("R10 after", lkHit, lkUsage, 1'b1, 32'h00900000);
    // R2: one-cycle latency, result held only while requested
    idle();
    @(negedge clk);
    check("R2 drop", lkHit, lkUsage, 1'b0, 32'h0);

    // R1: reset mid-run empties every thread
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    lkValid = 1'b1; lkThread = 3'd0; lkPc = 32'h400;
    @(negedge clk);
    check("R1 reset thread0", lkHit, lkUsage, 1'b0, 32'h0);
    lkThread = 3'd2; lkPc = 32'h700;
    @(negedge clk);
    check("R1 reset thread2", lkHit, lkUsage, 1'b0, 32'h0);
    idle();
    @(negedge clk);
    finishRun();
  end
endmodule